// File: doc/BRIEF.md
# Page Write Buffer and Timed Programming Engine

This block sits between a serial memory bus controller and a 128 x 8 non-volatile storage array. While a write transaction is open it gathers the data bytes into a 16-byte staging buffer. Each byte goes to a slot chosen by the low four bits of a running address. The three upper address bits stay fixed for the whole transaction, so a long transfer wraps back to the start of the same 16-byte page. When a transfer carries more bytes than the page holds, later bytes replace earlier ones. A 16-bit occupancy mask records which slots hold data.

Nothing reaches the array until the controller signals that the transaction ended with a stop. At that point the engine raises a busy flag for a fixed number of system clocks, set by a parameter. During the first part of that window it drives the occupied slots onto the array write port, one slot per clock. Slots that received no byte are never written, so their old contents stay in place. While busy, the block ignores every strobe from the controller. A start seen before any stop discards the buffer, and nothing is programmed.

Top module: `page_prog_engine`

## Requirements
- R1: After reset, busy is low, the write enable is low, and the occupancy mask is empty, so a commit issued straight after reset starts no cycle. Reset never drives the array write port.
- R2: An address load sets the page to address bits [6:4] and the slot pointer to bits [3:0]. It also opens a new transaction, discarding bytes buffered before it.
- R3: Each accepted byte is stored in the slot named by the pointer. The pointer then advances by one modulo 16, and the page bits never change, so slot 15 is followed by slot 0 of the same page.
- R4: When more than 16 bytes arrive, each slot keeps the last byte written to it in arrival order.
- R5: A commit accepted with a non-empty mask raises busy on the clock after the commit. Busy stays high for exactly WR_CYCLES clocks, or for 16 clocks if WR_CYCLES is smaller.
- R6: A commit with an empty mask has no effect.
- R7: In busy clock k, for k from 0 to 15, the write enable is high exactly when slot k is occupied, with address {page, k} and the byte held in slot k. No write happens in any other clock.
- R8: While busy, byte, address-load, commit and abort strobes are all ignored. They do not lengthen the cycle or change the buffer.
- R9: An abort discards every buffered byte without programming, so a later commit has no effect.
- R10: When strobes coincide, abort wins over address load, address load wins over commit, and commit wins over a byte; a losing strobe has no effect.
- R11: When a cycle ends, the mask is empty, so a repeated commit starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| addr_ld_i | input | 1 | Load start address, opens a transaction |
| addr_i | input | 7 | Start address |
| byte_stb_i | input | 1 | One received data byte |
| byte_i | input | 8 | Data byte |
| commit_i | input | 1 | Stop seen, program the buffer |
| abort_i | input | 1 | Start seen before stop, discard the buffer |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | 7 | Array write address |
| arr_wdata_o | output | 8 | Array write data |
| busy_o | output | 1 | Programming cycle in progress |

## Verification
The hardest states to reach are a strobe that arrives inside a running programming window and a buffer whose slots were overwritten several times over a page wrap. Neither state shows on the ports until a later cycle. The stimulus sweeps every start slot against transfer lengths of 1, 2, 15, 16, 17 and 33 bytes, and checks the write port clock by clock against a bench model of the slot contents. In one run it fires all four strobes together in the middle of a busy window, then issues a fresh commit. That commit must start nothing, which shows that the buffer was neither changed nor refilled.

// File: rtl/ppe_pkg.sv
package ppe_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_ABORT  = 3'd1,
        OP_LOAD   = 3'd2,
        OP_COMMIT = 3'd3,
        OP_BYTE   = 3'd4
    } ppe_op_e;

    // Fixed priority among coinciding strobes (R10)
    function automatic ppe_op_e ppe_decode(input logic ab, input logic ld,
                                           input logic cm, input logic bs);
        ppe_op_e op;
        if (ab)      op = OP_ABORT;
        else if (ld) op = OP_LOAD;
        else if (cm) op = OP_COMMIT;
        else if (bs) op = OP_BYTE;
        else         op = OP_NONE;
        return op;
    endfunction

endpackage

// File: rtl/ppe_fill.sv
module ppe_fill
    import ppe_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  ppe_op_e                                 op_i,
    input  logic [ADDR_W-1:0]                       addr_i,
    input  logic [DATA_W-1:0]                       byte_i,
    input  logic                                    busy_i,
    input  logic                                    done_i,
    output logic [ADDR_W-PAGE_W-1:0]                page_o,
    output logic [(1<<PAGE_W)-1:0]                  mask_o,
    output logic [(1<<PAGE_W)-1:0][DATA_W-1:0]      slots_o,
    output logic                                    any_o
);
    localparam int SLOTS = 1 << PAGE_W;
    localparam int HI_W  = ADDR_W - PAGE_W;

    typedef struct packed {
        logic [HI_W-1:0]                 page;
        logic [PAGE_W-1:0]               ptr;
        logic [SLOTS-1:0]                mask;
        logic [SLOTS-1:0][DATA_W-1:0]    data;
    } fill_st_t;

    fill_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (op_i)
            OP_ABORT: s_d.mask = '0;
            OP_LOAD: begin
                s_d.page = addr_i[ADDR_W-1:PAGE_W];
                s_d.ptr  = addr_i[PAGE_W-1:0];
                s_d.mask = '0;
            end
            OP_BYTE: begin
                s_d.data[s_q.ptr] = byte_i;
                s_d.mask[s_q.ptr] = 1'b1;
                s_d.ptr           = s_q.ptr + 1'b1;
            end
            default: ;
        endcase
        if (done_i) s_d.mask = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign page_o  = s_q.page;
    assign mask_o  = s_q.mask;
    assign slots_o = s_q.data;
    assign any_o   = |s_q.mask;

    // R3: an accepted byte lands in the slot the pointer named
    a_r3_byte_lands: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_BYTE |=> s_q.mask[$past(s_q.ptr)] &&
                            s_q.data[$past(s_q.ptr)] == $past(byte_i));
    // R3: a byte never moves the page
    a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_BYTE |=> $stable(s_q.page));
    // R8: buffer frozen while programming runs
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i && !done_i |=> $stable(s_q.mask) && $stable(s_q.data));
    // R11: mask empty after the cycle ends
    a_r11_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> s_q.mask == '0);

endmodule

// File: rtl/ppe_timer.sv
module ppe_timer
    import ppe_pkg::*;
#(
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ppe_op_e           op_i,
    input  logic              any_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              scan_act_o,
    output logic [PAGE_W-1:0] scan_o
);
    localparam int SLOTS = 1 << PAGE_W;
    localparam int EFF   = (WR_CYCLES < SLOTS) ? SLOTS : WR_CYCLES;
    localparam int CNT_W = $clog2(EFF + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(EFF - 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [PAGE_W:0]   scan;
    } tim_st_t;

    tim_st_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!t_q.busy) begin
            if (op_i == OP_COMMIT && any_i) begin
                t_d.busy = 1'b1;
                t_d.cnt  = '0;
                t_d.scan = '0;
            end
        end else begin
            if (!t_q.scan[PAGE_W]) t_d.scan = t_q.scan + 1'b1;
            if (t_q.cnt == LAST) t_d.busy = 1'b0;
            else                 t_d.cnt  = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy_o     = t_q.busy;
    assign done_o     = t_q.busy && (t_q.cnt == LAST);
    assign scan_act_o = t_q.busy && !t_q.scan[PAGE_W];
    assign scan_o     = t_q.scan[PAGE_W-1:0];

    // R5: busy holds until the last count
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.busy && t_q.cnt != LAST |=> t_q.busy);
    // R5: busy drops right after the last count
    a_r5_end: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.busy && t_q.cnt == LAST |=> !t_q.busy);
    // R5: counter never passes the window
    a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.busy |-> t_q.cnt <= LAST);

endmodule

// File: rtl/page_prog_engine.sv
module page_prog_engine
    import ppe_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int PAGE_W    = 4,
    parameter int DATA_W    = 8,
    parameter int WR_CYCLES = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_ld_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_stb_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              commit_i,
    input  logic              abort_i,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_wdata_o,
    output logic              busy_o
);
    localparam int SLOTS = 1 << PAGE_W;
    localparam int HI_W  = ADDR_W - PAGE_W;

    ppe_op_e                          op;
    logic                             busy, done, scan_act, any;
    logic [PAGE_W-1:0]                scan;
    logic [HI_W-1:0]                  page;
    logic [SLOTS-1:0]                 mask;
    logic [SLOTS-1:0][DATA_W-1:0]     slots;

    // Strobes are dropped entirely while a cycle runs (R8)
    always_comb begin
        op = ppe_decode(abort_i, addr_ld_i, commit_i, byte_stb_i);
        if (busy) op = OP_NONE;
    end

    ppe_fill #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .op_i(op), .addr_i(addr_i), .byte_i(byte_i),
        .busy_i(busy), .done_i(done), .page_o(page), .mask_o(mask),
        .slots_o(slots), .any_o(any)
    );

    ppe_timer #(.PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .op_i(op), .any_i(any), .busy_o(busy),
        .done_o(done), .scan_act_o(scan_act), .scan_o(scan)
    );

    assign arr_we_o    = scan_act && mask[scan];
    assign arr_addr_o  = {page, scan};
    assign arr_wdata_o = slots[scan];
    assign busy_o      = busy;

    // R7: the array is written only inside a programming window
    a_r7_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> busy_o);
    // R5: a window opens only on a commit
    a_r5_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(commit_i));
    // R6: a commit with an empty buffer leaves the engine idle
    a_r6_empty_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && commit_i && !any |=> !busy_o);

endmodule

// File: tb/sim_page_prog_engine.sv
module sim_page_prog_engine;
    localparam int WRC = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_ld = 1'b0, byte_stb = 1'b0, commit = 1'b0, abort = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] bdata = '0;
    logic       arr_we, busy;
    logic [6:0] arr_addr;
    logic [7:0] arr_wdata;

    int total = 0;
    int fails = 0;

    logic [2:0]  m_page = '0;
    logic [3:0]  m_ptr  = '0;
    logic [15:0] m_mask = '0;
    logic [7:0]  m_buf [16];

    always #5 clk = ~clk;

    page_prog_engine #(.WR_CYCLES(WRC)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_ld_i(addr_ld), .addr_i(addr),
        .byte_stb_i(byte_stb), .byte_i(bdata), .commit_i(commit), .abort_i(abort),
        .arr_we_o(arr_we), .arr_addr_o(arr_addr), .arr_wdata_o(arr_wdata),
        .busy_o(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One strobe cycle with the bench model updated by priority (R10)
    task automatic step(input bit ab, input bit ld, input logic [6:0] a,
                        input bit bs, input logic [7:0] d);
        abort = ab; addr_ld = ld; addr = a; byte_stb = bs; bdata = d;
        if (ab) m_mask = '0;
        else if (ld) begin
            m_page = a[6:4]; m_ptr = a[3:0]; m_mask = '0;
        end else if (bs) begin
            m_buf[m_ptr] = d; m_mask[m_ptr] = 1'b1; m_ptr = m_ptr + 1'b1;
        end
        @(negedge clk);
        abort = 0; addr_ld = 0; byte_stb = 0;
    endtask

    task automatic expect_idle(input int n, input string req);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            chk(!busy && !arr_we, req, busy, 0);
        end
    endtask

    task automatic commit_check(input bit bs, input logic [7:0] d, input bit inj,
                                input string req);
        bit exp_busy = (m_mask != 0);
        commit = 1; byte_stb = bs; bdata = d;
        for (int c = 0; c < WRC + 4; c++) begin
            bit exp_we;
            @(negedge clk);
            if (c == 0) begin commit = 0; byte_stb = 0; end
            if (inj && c == 3) begin
                commit = 1; byte_stb = 1; addr_ld = 1; abort = 1;
                addr = 7'h7f; bdata = 8'hee;
            end
            if (inj && c == 4) begin
                commit = 0; byte_stb = 0; addr_ld = 0; abort = 0;
            end
            chk(busy == (exp_busy && c < WRC), "R5 busy window", busy,
                int'(exp_busy && c < WRC));
            exp_we = exp_busy && c < 16 && m_mask[c % 16];
            chk(arr_we == exp_we, {req, " write enable"}, arr_we, exp_we);
            if (exp_we && arr_we) begin
                chk(arr_addr == {m_page, 4'(c)}, {req, " R7 address"},
                    arr_addr, {m_page, 4'(c)});
                chk(arr_wdata == m_buf[c], {req, " R7 data"}, arr_wdata, m_buf[c]);
            end
        end
        if (exp_busy) m_mask = '0;
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int lens [6] = '{1, 2, 15, 16, 17, 33};
        for (int i = 0; i < 16; i++) m_buf[i] = '0;
        // R1: quiet during and after reset
        repeat (3) begin
            @(negedge clk);
            chk(!busy && !arr_we, "R1 in reset", busy, 0);
        end
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !arr_we, "R1 after reset", busy, 0);
        // R1 R6: commit on an empty buffer
        commit_check(0, 8'h00, 0, "R1 R6");

        // R3 R4 R7 sweep: every start slot against several lengths
        for (int off = 0; off < 16; off++) begin
            for (int li = 0; li < 6; li++) begin
                logic [2:0] pg = 3'((off + li * 3) % 8);
                step(0, 1, {pg, 4'(off)}, 0, 8'h00);
                for (int i = 0; i < lens[li]; i++)
                    step(0, 0, 7'h00, 1, 8'((off * 37 + li * 91 + i * 13 + 5) & 255));
                commit_check(0, 8'h00, 0, "R3 R4 R7");
            end
        end

        // R2: a second address load discards earlier bytes
        step(0, 1, 7'h05, 0, 0);
        step(0, 0, 0, 1, 8'ha1);
        step(0, 0, 0, 1, 8'ha2);
        step(0, 1, 7'h62, 0, 0);
        step(0, 0, 0, 1, 8'hb7);
        commit_check(0, 8'h00, 0, "R2");

        // R9: abort discards, later commit does nothing
        step(0, 1, 7'h31, 0, 0);
        step(0, 0, 0, 1, 8'h11);
        step(0, 0, 0, 1, 8'h22);
        step(1, 0, 0, 0, 0);
        commit_check(0, 8'h00, 0, "R9");
        expect_idle(4, "R9 idle");

        // R10: abort beats byte
        step(0, 1, 7'h20, 0, 0);
        step(0, 0, 0, 1, 8'h33);
        step(1, 0, 0, 1, 8'h44);
        commit_check(0, 8'h00, 0, "R10 abort-byte");
        // R10: address load beats byte
        step(0, 1, 7'h35, 0, 0);
        step(0, 1, 7'h47, 1, 8'h55);
        step(0, 0, 0, 1, 8'h66);
        commit_check(0, 8'h00, 0, "R10 load-byte");
        // R10: commit beats byte
        step(0, 1, 7'h10, 0, 0);
        step(0, 0, 0, 1, 8'h77);
        step(0, 0, 0, 1, 8'h88);
        commit_check(1, 8'h99, 0, "R10 commit-byte");
        // R10: abort beats commit
        step(0, 1, 7'h58, 0, 0);
        step(0, 0, 0, 1, 8'h12);
        commit = 1;
        step(1, 0, 0, 0, 0);
        commit = 0;
        chk(!busy, "R10 abort-commit", busy, 0);
        expect_idle(3, "R10 abort-commit idle");

        // R8: strobes during a busy window are ignored
        step(0, 1, 7'h7c, 0, 0);
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 8'(8'hc0 + i));
        commit_check(0, 8'h00, 1, "R8");
        // R8 R11: the buffer is empty afterwards, nothing restarts
        commit_check(0, 8'h00, 0, "R8 R11");
        expect_idle(3, "R11 idle");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule